// File: doc/BRIEF.md
# Single-Wire Identifier Responder

This block is a synchronous slave on an open-drain single-wire bus. It owns a fixed 64-bit identifier and answers only two operations: a full readout of that identifier and a bit-by-bit tree search, which lets a master find every responder on a shared line. The block runs from a system clock and a one-cycle pulse once per microsecond. It derives all bus timing from falling edges of the line, which it first passes through a two-flop synchronizer. The block drives the line through a single pull-down enable. The wired-AND of the line is formed outside the block.

A transaction opens with a long low period from the master. The block answers that low with a presence pulse. It then collects an eight-bit command, least significant bit first, one bit per write slot. If the command is the readout or the search, the block serves it. For any other command it stays off the line until the next long low. A long low seen in any state abandons the transaction in progress and restarts the presence sequence.

The identifier is built from two parameters: an eight-bit family code and a 48-bit serial number. The block appends a check byte computed from these two parameters.

The block sits on a half-duplex bus with no back-pressure. The bus itself sets the pace, slot by slot. For this reason the block has plain control pins and no valid/ready handshake.

Top module: `sw_rom_slave`

## Requirements
- R1: When the line has been low for at least 480 µs and then returns high, the block waits 30 µs and then asserts `pull_dn` for 120 µs as a presence pulse. Both figures lie inside the allowed windows of 15–60 µs and 60–240 µs.
- R2: After reset `pull_dn` is low, and it stays low for as long as the line is held low for a reset. A reset low that arrives in any state, including in the middle of a readout, abandons that transaction. A complete presence pulse follows, and a new command is accepted after it.
- R3: After the presence pulse the block receives exactly eight write slots as the command, least significant bit first. It never asserts `pull_dn` while it is receiving the command.
- R4: In a write slot the block samples the line 30 µs after the falling edge. If the line is still low, the bit is 0; otherwise the bit is 1. Command bytes that differ in a single bit, including bit 0 and bit 7, are therefore told apart.
- R5: After command 33h the block answers 64 read slots with the identifier, least significant bit first. Bits 0–7 carry the family code (01h by default). Bits 8–55 carry the serial number. Bits 56–63 carry a check byte formed with the polynomial x^8+x^5+x^4+1. That check byte is computed from a zero start, taking bits 0 to 55 one at a time, least significant first. Running the same calculation over all 64 bits gives zero.
- R6: In a read slot, to send a 0 the block asserts `pull_dn` from the falling edge it detects until 30 µs after that edge. To send a 1 it leaves `pull_dn` low for the whole slot.
- R7: After command F0h the block runs 64 triplets, one per identifier bit. In each triplet it sends the bit, then sends the complement of the bit, then samples the master's choice. When the choice matches, it continues with the next bit.
- R8: If the master's choice in a search triplet differs from the block's bit, the block stays silent in every later slot until the next reset low.
- R9: Any command other than 33h and F0h leaves the block silent in every following slot until the next reset low. This includes 55h, CCh, 32h, B3h and 70h.
- R10: Once the 64th identifier bit of a readout or a search has been served, the block stays silent until the next reset low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_in | input | 1 | Level of the bus line (1 = released); synchronized inside |
| us_tick | input | 1 | One-cycle pulse once per microsecond |
| pull_dn | output | 1 | Enables the open-drain pull-down of the line when 1 |

## Verification
Two events land on the same clock edge. One is the write-slot sample of the eighth command bit. The other is the command decode that picks the next state. Because they coincide, the decode has to use the bit being sampled in that cycle, not the old contents of the shift register. The bench provokes this with command bytes that differ from a served command only in bit 7 (B3h against 33h, 70h against F0h) or only in bit 0 (32h). It judges the result by whether the slots that follow are answered. In the same way, the decision to leave a search coincides with the sample of the master's choice. The bench sweeps the position of a losing bit (0, 9 and 40) and checks that the very next triplet is silent.

// File: rtl/sw_pkg.sv
package sw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RSTLOW,
    ST_PD_WAIT,
    ST_PD_LOW,
    ST_CMD,
    ST_READ,
    ST_SRCH
  } sw_state_e;

  localparam logic [7:0] OPC_READOUT = 8'h33;
  localparam logic [7:0] OPC_SEARCH  = 8'hF0;

  // Check byte over the first 56 identifier bits, taken LSB first from a zero start.
  function automatic logic [7:0] id_check8(input logic [55:0] d);
    logic [7:0] c;
    logic       fb;
    c = 8'h00;
    for (int i = 0; i < 56; i++) begin
      fb = c[0] ^ d[i];
      c  = c >> 1;
      if (fb) c = c ^ 8'h8C;
    end
    return c;
  endfunction

endpackage

// File: rtl/sw_line_front.sv
module sw_line_front #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_in,
  output logic line,
  output logic fall,
  output logic rise
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sync_q <= '1;
        else        sync_q <= bus_in;
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[STAGES-2:0], bus_in};
    end
  endgenerate

  assign line = sync_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= line;

  assign fall = prev_q & ~line;
  assign rise = ~prev_q & line;
endmodule

// File: rtl/sw_us_timer.sv
module sw_us_timer #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         tick,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                 cnt <= '0;
    else if (clr)               cnt <= '0;
    else if (tick && cnt != '1) cnt <= cnt + 1'b1;
endmodule

// File: rtl/sw_rom_slave.sv
module sw_rom_slave
  import sw_pkg::*;
#(
  parameter logic [7:0]  FAMILY       = 8'h01,
  parameter logic [47:0] SERIAL       = 48'h3A5C_0071_9E24,
  parameter int          SYNC_STAGES  = 2,
  parameter int          TW           = 10,
  parameter int          RST_US       = 480,
  parameter int          PD_WAIT_US   = 30,
  parameter int          PD_LEN_US    = 120,
  parameter int          SLOT_MARK_US = 30
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_in,
  input  logic us_tick,
  output logic pull_dn
);
  localparam int              ID_BITS = 64;
  localparam int              IW      = $clog2(ID_BITS);
  localparam int              CMD_BITS = 8;
  localparam int              CW      = $clog2(CMD_BITS);
  localparam logic [ID_BITS-1:0] ROM_ID = {id_check8({SERIAL, FAMILY}), SERIAL, FAMILY};
  localparam logic [TW-1:0]   T_RST   = TW'(RST_US);
  localparam logic [TW-1:0]   T_WAIT  = TW'(PD_WAIT_US);
  localparam logic [TW-1:0]   T_PD    = TW'(PD_LEN_US);
  localparam logic [TW-1:0]   T_MARK  = TW'(SLOT_MARK_US);
  localparam logic [IW-1:0]   LAST_BIT = IW'(ID_BITS - 1);
  localparam logic [CW-1:0]   LAST_CMD = CW'(CMD_BITS - 1);

  logic          line, fall, rise;
  logic [TW-1:0] low_us, ph_us;
  sw_state_e     state_q, state_n;
  logic          slot_q;
  logic [IW-1:0] bit_q;
  logic [1:0]    tri_q;
  logic [CMD_BITS-1:0] cmd_q, cmd_full;
  logic [CW-1:0] cmd_cnt_q;
  logic          in_slot_state, slot_done, rst_hit, rom_bit, out_bit, drive_phase, ph_clr;

  sw_line_front #(.STAGES(SYNC_STAGES)) u_front (
    .clk(clk), .rst_n(rst_n), .bus_in(bus_in),
    .line(line), .fall(fall), .rise(rise)
  );

  // Length of the current low period; cleared whenever the line is high.
  sw_us_timer #(.W(TW)) u_low_tmr (
    .clk(clk), .rst_n(rst_n), .clr(line), .tick(us_tick), .cnt(low_us)
  );

  // Phase timer: time since slot start or since the last state change.
  sw_us_timer #(.W(TW)) u_ph_tmr (
    .clk(clk), .rst_n(rst_n), .clr(ph_clr), .tick(us_tick), .cnt(ph_us)
  );

  assign in_slot_state = (state_q == ST_CMD) || (state_q == ST_READ) || (state_q == ST_SRCH);
  assign slot_done     = slot_q && (ph_us >= T_MARK);
  assign rst_hit       = (low_us >= T_RST) && (state_q != ST_RSTLOW);
  assign rom_bit       = ROM_ID[bit_q];
  assign drive_phase   = (state_q == ST_READ) || ((state_q == ST_SRCH) && (tri_q != 2'd2));
  assign out_bit       = ((state_q == ST_SRCH) && (tri_q == 2'd1)) ? ~rom_bit : rom_bit;
  assign cmd_full      = {line, cmd_q[CMD_BITS-1:1]};
  assign ph_clr        = (fall && in_slot_state) || (state_n != state_q);

  always_comb begin
    state_n = state_q;
    unique case (state_q)
      ST_RSTLOW:  if (rise) state_n = ST_PD_WAIT;
      ST_PD_WAIT: if (ph_us >= T_WAIT) state_n = ST_PD_LOW;
      ST_PD_LOW:  if (ph_us >= T_PD) state_n = ST_CMD;
      ST_CMD:
        if (slot_done && cmd_cnt_q == LAST_CMD) begin
          if (cmd_full == OPC_READOUT)     state_n = ST_READ;
          else if (cmd_full == OPC_SEARCH) state_n = ST_SRCH;
          else                             state_n = ST_IDLE;
        end
      ST_READ:
        if (slot_done && bit_q == LAST_BIT) state_n = ST_IDLE;
      ST_SRCH:
        if (slot_done && tri_q == 2'd2 && ((line != rom_bit) || (bit_q == LAST_BIT)))
          state_n = ST_IDLE;
      default: state_n = state_q;
    endcase
    if (rst_hit) state_n = ST_RSTLOW;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      slot_q    <= 1'b0;
      bit_q     <= '0;
      tri_q     <= 2'd0;
      cmd_q     <= '0;
      cmd_cnt_q <= '0;
    end else begin
      state_q <= state_n;
      if (state_n != state_q) begin
        slot_q    <= 1'b0;
        bit_q     <= '0;
        tri_q     <= 2'd0;
        cmd_cnt_q <= '0;
      end else begin
        if (fall && in_slot_state) slot_q <= 1'b1;
        else if (slot_done)        slot_q <= 1'b0;
        if (slot_done) begin
          unique case (state_q)
            ST_CMD: begin
              cmd_q     <= cmd_full;
              cmd_cnt_q <= cmd_cnt_q + 1'b1;
            end
            ST_READ: bit_q <= bit_q + 1'b1;
            ST_SRCH:
              if (tri_q == 2'd2) begin
                tri_q <= 2'd0;
                bit_q <= bit_q + 1'b1;
              end else begin
                tri_q <= tri_q + 1'b1;
              end
            default: ;
          endcase
        end
      end
    end

  assign pull_dn = (state_q == ST_PD_LOW) || (slot_q && drive_phase && !out_bit);
endmodule

// File: rtl/sw_rom_slave_chk.sv
module sw_rom_slave_chk
  import sw_pkg::*;
#(
  parameter int PD_WAIT_US   = 30,
  parameter int PD_LEN_US    = 120,
  parameter int SLOT_MARK_US = 30
) (
  input logic      clk,
  input logic      rst_n,
  input logic      us_tick,
  input logic      pull_dn,
  input sw_state_e st
);
  logic [11:0] pd_us, wt_us, drv_us;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pd_us  <= '0;
      wt_us  <= '0;
      drv_us <= '0;
    end else begin
      pd_us  <= (st == ST_PD_LOW)  ? pd_us + {11'd0, us_tick} : '0;
      wt_us  <= (st == ST_PD_WAIT) ? wt_us + {11'd0, us_tick} : '0;
      drv_us <= (pull_dn && st != ST_PD_LOW) ? drv_us + {11'd0, us_tick} : '0;
    end

  // R1
  pd_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_CMD && $past(st) == ST_PD_LOW) |-> $past(pd_us) >= 12'(PD_LEN_US));

  // R1
  pd_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pd_us <= 12'(PD_LEN_US + 1));

  // R1
  pd_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_PD_LOW && $past(st) == ST_PD_WAIT) |-> $past(wt_us) >= 12'(PD_WAIT_US));

  // R2
  rst_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RSTLOW) |-> !pull_dn);

  // R3
  cmd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_CMD) |-> !pull_dn);

  // R6
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drv_us <= 12'(SLOT_MARK_US + 1));

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> !pull_dn);
endmodule

bind sw_rom_slave sw_rom_slave_chk #(
  .PD_WAIT_US(PD_WAIT_US), .PD_LEN_US(PD_LEN_US), .SLOT_MARK_US(SLOT_MARK_US)
) u_chk (
  .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .pull_dn(pull_dn), .st(state_q)
);

// File: tb/sw_rom_slave_tb.sv
module sw_rom_slave_tb;
  localparam int          CLK_NS = 10;
  localparam int          WDOG   = 190000;
  localparam logic [7:0]  FAM    = 8'h01;
  localparam logic [47:0] SER    = 48'h3A5C_0071_9E24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic us_tick = 1'b0;
  logic m_low = 1'b0;
  logic pull_dn;
  wire  bus_in = ~(m_low | pull_dn);

  int n_chk = 0;
  int n_err = 0;
  logic [63:0] exp_id;

  always #(CLK_NS/2) clk = ~clk;

  sw_rom_slave #(.FAMILY(FAM), .SERIAL(SER)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_in(bus_in), .us_tick(us_tick), .pull_dn(pull_dn)
  );

  initial forever begin
    @(negedge clk) us_tick = 1'b1;
    @(negedge clk) us_tick = 1'b0;
  end

  function automatic logic [7:0] tb_crc(input logic [63:0] d, input int n);
    logic [7:0] c = 8'h00;
    for (int i = 0; i < n; i++) begin
      logic fb = c[0] ^ d[i];
      c = c >> 1;
      if (fb) c = c ^ 8'h8C;
    end
    return c;
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_us(input int n);
    repeat (2 * n) @(negedge clk);
  endtask

  task automatic reset_pres(input string tag);
    m_low = 1'b1;
    wait_us(490);
    chk(!pull_dn, {tag, " R2 quiet during reset low"}, pull_dn, 0);
    wait_us(10);
    m_low = 1'b0;
    wait_us(10);
    chk(!pull_dn, {tag, " R1 no presence yet"}, pull_dn, 0);
    wait_us(50);
    chk(pull_dn, {tag, " R1 presence active"}, pull_dn, 1);
    wait_us(140);
    chk(!pull_dn, {tag, " R1 presence ended"}, pull_dn, 0);
    wait_us(40);
  endtask

  task automatic wr_bit(input logic b);
    m_low = 1'b1;
    wait_us(b ? 5 : 65);
    m_low = 1'b0;
    wait_us(b ? 65 : 5);
  endtask

  task automatic wr_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) wr_bit(v[i]);
  endtask

  task automatic rd_bit(output logic v);
    m_low = 1'b1;
    wait_us(3);
    m_low = 1'b0;
    wait_us(12);
    v = bus_in;
    wait_us(55);
  endtask

  initial begin
    logic v, a, b;
    logic [63:0] got;
    logic [7:0] byt;
    logic [7:0] bad_cmds [9];
    int loses [3];
    exp_id = {tb_crc({8'h00, SER, FAM}, 56), SER, FAM};
    bad_cmds = '{8'h55, 8'hCC, 8'h00, 8'hFF, 8'h32, 8'hB3, 8'h70, 8'h0F, 8'hF1};
    loses = '{0, 9, 40};

    repeat (5) @(negedge clk);
    chk(!pull_dn, "R2 reset state", pull_dn, 0);
    rst_n = 1'b1;
    wait_us(20);
    chk(!pull_dn, "R2 idle after reset", pull_dn, 0);

    // Readout
    reset_pres("rd");
    wr_byte(8'h33);
    got = '0;
    for (int i = 0; i < 64; i++) begin
      rd_bit(v);
      got[i] = v;
      chk(v == exp_id[i], "R6 readout bit", v, exp_id[i]);
    end
    chk(got == exp_id, "R5 identifier", got, exp_id);
    chk(got[7:0] == 8'h01, "R5 family code", got[7:0], 8'h01);
    chk(tb_crc(got, 64) == 8'h00, "R5 check residue", tb_crc(got, 64), 0);
    rd_bit(v); chk(v, "R10 silent after readout", v, 1);
    rd_bit(v); chk(v, "R10 silent after readout", v, 1);

    // Full search
    reset_pres("sr");
    wr_byte(8'hF0);
    for (int i = 0; i < 64; i++) begin
      rd_bit(a); rd_bit(b);
      chk(a == exp_id[i] && b == !exp_id[i], "R7 search triplet", {a, b}, {exp_id[i], !exp_id[i]});
      wr_bit(exp_id[i]);
    end
    rd_bit(a); rd_bit(b);
    chk(a && b, "R10 silent after search", {a, b}, 2'b11);

    // Search with a losing bit at several positions
    foreach (loses[j]) begin
      reset_pres("ls");
      wr_byte(8'hF0);
      for (int i = 0; i <= loses[j]; i++) begin
        rd_bit(a); rd_bit(b);
        chk(a == exp_id[i] && b == !exp_id[i], "R7 search before loss", {a, b}, {exp_id[i], !exp_id[i]});
        wr_bit(i == loses[j] ? !exp_id[i] : exp_id[i]);
      end
      for (int k = 0; k < 2; k++) begin
        rd_bit(a); rd_bit(b);
        chk(a && b, "R8 silent after loss", {a, b}, 2'b11);
        wr_bit(1'b0);
      end
    end

    // Unsupported commands, including single-bit neighbours of served ones
    foreach (bad_cmds[j]) begin
      reset_pres("uc");
      wr_byte(bad_cmds[j]);
      byt = '0;
      for (int i = 0; i < 8; i++) begin
        rd_bit(v);
        byt[i] = v;
      end
      chk(byt == 8'hFF, "R9 R4 silent on other command", byt, 8'hFF);
    end

    // Abort in the middle of a readout
    reset_pres("ab");
    wr_byte(8'h33);
    for (int i = 0; i < 12; i++) rd_bit(v);
    reset_pres("ab2");
    wr_byte(8'h33);
    byt = '0;
    for (int i = 0; i < 8; i++) begin
      rd_bit(v);
      byt[i] = v;
    end
    chk(byt == FAM, "R2 R3 restart after abort", byt, FAM);

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL R1 watchdog act=0 exp=1");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule